// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block produces the clock line timing for an I2C master. A programmable prescaler turns the system clock into a slow tick. Each SCL low phase and each SCL high phase then lasts a set number of those ticks, from 2 to 9. The line is driven open-drain: the block only ever pulls SCL low or lets it go. It watches the line through a synchronised readback, so a target that holds SCL low (clock stretching) delays the start of the high phase.

A byte engine sits beside the block. It raises `byte_req` for as long as it wants clock pulses. It uses four one-cycle strobes to place its SDA activity: the start of each low phase, the middle of the low phase (drive SDA), the first counted high cycle, and the middle of the high phase (sample SDA). Configuration arrives through a small write port. One write holds the divisor. Another holds a packed timing word, either written directly or built in hardware from requested tick counts, which are clamped to the legal range. New settings are picked up only at phase boundaries, so a phase in progress is never cut short or stretched by a write.

The block carries no data stream. All of its pins are plain levels or single-cycle strobes with no back-pressure. A strobe is never held waiting for the byte engine; the engine must act in the cycle the strobe is high.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset the block is idle, `scl_pull_low` is 0 and no strobe is high. The divisor and the timing word reset to 0, so a transfer started without any write uses 2 ticks per phase and 1 clock per tick.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata` as divisor N (0 to 65535). Ticks then come every N+1 clocks, and every phase length is counted in those ticks.
- R3: A write with `cfg_sel`=1 stores the timing word. The high field is taken from `cfg_wdata[6:4]` and the low field from `cfg_wdata[2:0]`. Each low phase holds `scl_pull_low` at 1 for exactly (low field + 2)·(N+1) consecutive cycles.
- R4: After a low phase SCL is released. Once the readback shows the line high, high-phase counting starts SYNC_STAGES+1 cycles after the line rises. The high phase lasts (high field + 2)·(N+1) cycles.
- R5: A write with `cfg_sel`=2 takes a requested high tick count from `cfg_wdata[15:8]` and a requested low tick count from `cfg_wdata[7:0]`. Each count is forced into 2..9 and stored as count−2 in its field. A write with `cfg_sel`=3 changes nothing.
- R6: While SCL is released but `scl_in` reads low, the high phase does not start, `rise_stb` stays 0 and the line stays released.
- R7: `upd_stb` is high for one cycle: the last cycle of tick floor(L/2) of each low phase of L ticks. `smp_stb` is high in the last cycle of tick floor(H/2) of each high phase of H ticks.
- R8: `fall_stb` is high in the first cycle of each low phase. `rise_stb` is high in the first counted cycle of each high phase.
- R9: The divisor and timing fields in use are loaded only at phase boundaries: when a low phase begins, and when a low phase ends. A write made during a low phase leaves that low phase unchanged and takes effect from the following high phase.
- R10: From idle, `gen_en`=1 with `byte_req`=1 starts a low phase on the next clock. At the end of each high phase the block starts another low phase if `byte_req` is 1; otherwise it returns to idle with SCL released.
- R11: `gen_en`=0 sends the block to idle with SCL released on the next clock, even in the middle of a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generator enable; 0 forces idle |
| byte_req | input | 1 | Byte engine asks for clock pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 divisor, 1 timing word, 2 clamped request, 3 none |
| cfg_wdata | input | DIV_W | Write data |
| scl_in | input | 1 | SCL line readback |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | First cycle of a low phase |
| upd_stb | output | 1 | Middle of low phase, SDA may change |
| rise_stb | output | 1 | First counted cycle of a high phase |
| smp_stb | output | 1 | Middle of high phase, SDA may be sampled |

## Verification
The timing is tried with several divisor and tick-count settings: the reset defaults, a fast divisor with unequal fields, a divisor of 1000, and odd and even phase lengths. These tell apart errors in tick spacing, in which field sets which phase, and in where the middle strobes fall. Clamped request writes below 2, above 9 and in range show whether the floor, the ceiling and the offset encoding are right. A write in the middle of a low phase checks that the settings change only at a phase boundary. A target holding SCL low checks that stretching delays the high phase, and dropping the enable in the middle of a phase checks the immediate release.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int unsigned FIELD_W   = 3;
  localparam int unsigned LEN_W     = FIELD_W + 1;
  localparam int unsigned MIN_TICKS = 2;
  localparam int unsigned MAX_TICKS = MIN_TICKS + (1 << FIELD_W) - 1;
  localparam int unsigned HI_LSB    = 4;
  localparam int unsigned LO_LSB    = 0;
  localparam int unsigned TIME_W    = HI_LSB + FIELD_W;
  localparam int unsigned REQ_W     = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_RWAIT = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_TIME = 2'd1,
    SEL_REQ  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // Clamp a requested tick count into the legal range and offset it.
  function automatic logic [FIELD_W-1:0] clamp_encode(input logic [REQ_W-1:0] ticks);
    logic [REQ_W-1:0] diff;
    if (ticks < REQ_W'(MIN_TICKS)) begin
      diff = '0;
    end else if (ticks > REQ_W'(MAX_TICKS)) begin
      diff = REQ_W'(MAX_TICKS - MIN_TICKS);
    end else begin
      diff = ticks - REQ_W'(MIN_TICKS);
    end
    return diff[FIELD_W-1:0];
  endfunction

  // Stored field back to a tick count.
  function automatic logic [LEN_W-1:0] field_to_len(input logic [FIELD_W-1:0] f);
    return LEN_W'(f) + LEN_W'(MIN_TICKS);
  endfunction
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= line_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DIV_W-1:0]  cfg_wdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [TIME_W-1:0] tim_q
);
  localparam int unsigned REQ_LO_LSB = 0;
  localparam int unsigned REQ_HI_LSB = REQ_W;
  localparam int unsigned GAP_W      = HI_LSB - LO_LSB - FIELD_W;

  logic [REQ_W-1:0]   req_hi, req_lo;
  logic [TIME_W-1:0]  packed_direct, packed_req;

  assign req_hi = cfg_wdata[REQ_HI_LSB +: REQ_W];
  assign req_lo = cfg_wdata[REQ_LO_LSB +: REQ_W];

  assign packed_direct = {cfg_wdata[HI_LSB +: FIELD_W], {GAP_W{1'b0}}, cfg_wdata[LO_LSB +: FIELD_W]};
  assign packed_req    = {clamp_encode(req_hi), {GAP_W{1'b0}}, clamp_encode(req_lo)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      tim_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_DIV:  div_q <= cfg_wdata;
        SEL_TIME: tim_q <= packed_direct;
        SEL_REQ:  tim_q <= packed_req;
        default:  ;
      endcase
    end
  end

  // R5: a request below the floor lands as the minimum field code
  p_clamp_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_REQ && req_hi < REQ_W'(MIN_TICKS))
      |=> (tim_q[HI_LSB +: FIELD_W] == '0));

  // R5: a request above the ceiling lands as the maximum field code
  p_clamp_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_REQ && req_lo > REQ_W'(MAX_TICKS))
      |=> (tim_q[LO_LSB +: FIELD_W] == '1));

  // R5: the unused select leaves both registers untouched
  p_sel_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_NONE) |=> ($stable(div_q) && $stable(tim_q)));
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pcnt;

  assign tick = run && (pcnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run || tick)   pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  // R2: with a non-zero divisor two ticks are never adjacent
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));

  // R2: the counter never passes the divisor while counting
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pcnt <= div));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req,
  input  logic              scl_hi,
  input  logic              tick,
  input  logic [DIV_W-1:0]  div_reg,
  input  logic [TIME_W-1:0] tim_reg,
  output logic              run,
  output logic [DIV_W-1:0]  div_act,
  output logic              pull_low,
  output logic              fall_stb,
  output logic              upd_stb,
  output logic              rise_stb,
  output logic              smp_stb
);
  phase_e           state;
  logic [LEN_W-1:0] tcnt;
  logic [LEN_W-1:0] lo_len, hi_len;
  logic [LEN_W-1:0] lo_half, hi_half;
  logic             last_low, last_high;
  logic             fall_q, rise_q;

  assign lo_half   = lo_len >> 1;
  assign hi_half   = hi_len >> 1;
  assign last_low  = (tcnt == lo_len - LEN_W'(1));
  assign last_high = (tcnt == hi_len - LEN_W'(1));

  assign run      = (state == PH_LOW) || (state == PH_HIGH);
  assign pull_low = (state == PH_LOW);
  assign fall_stb = fall_q;
  assign rise_stb = rise_q;
  assign upd_stb  = (state == PH_LOW)  && tick && (tcnt == lo_half - LEN_W'(1));
  assign smp_stb  = (state == PH_HIGH) && tick && (tcnt == hi_half - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      tcnt    <= '0;
      div_act <= '0;
      lo_len  <= LEN_W'(MIN_TICKS);
      hi_len  <= LEN_W'(MIN_TICKS);
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      if (!en) begin
        state <= PH_IDLE;
        tcnt  <= '0;
      end else begin
        case (state)
          PH_IDLE: begin
            if (req) begin
              state   <= PH_LOW;
              tcnt    <= '0;
              fall_q  <= 1'b1;
              div_act <= div_reg;
              lo_len  <= field_to_len(tim_reg[LO_LSB +: FIELD_W]);
              hi_len  <= field_to_len(tim_reg[HI_LSB +: FIELD_W]);
            end
          end
          PH_LOW: begin
            if (tick) begin
              if (last_low) begin
                state   <= PH_RWAIT;
                tcnt    <= '0;
                div_act <= div_reg;
                lo_len  <= field_to_len(tim_reg[LO_LSB +: FIELD_W]);
                hi_len  <= field_to_len(tim_reg[HI_LSB +: FIELD_W]);
              end else begin
                tcnt <= tcnt + LEN_W'(1);
              end
            end
          end
          PH_RWAIT: begin
            if (scl_hi) begin
              state  <= PH_HIGH;
              tcnt   <= '0;
              rise_q <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (tick) begin
              if (last_high) begin
                tcnt <= '0;
                if (req) begin
                  state   <= PH_LOW;
                  fall_q  <= 1'b1;
                  div_act <= div_reg;
                  lo_len  <= field_to_len(tim_reg[LO_LSB +: FIELD_W]);
                  hi_len  <= field_to_len(tim_reg[HI_LSB +: FIELD_W]);
                end else begin
                  state <= PH_IDLE;
                end
              end else begin
                tcnt <= tcnt + LEN_W'(1);
              end
            end
          end
          default: state <= PH_IDLE;
        endcase
      end
    end
  end

  // R6: a released line read as low keeps the high phase from starting
  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_RWAIT && !scl_hi) |=> (state != PH_HIGH));

  // R11: dropping the enable releases the line on the next clock
  p_disable_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pull_low && state == PH_IDLE));

  // R9: settings in use hold still for the whole of a low phase
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW && $past(state) == PH_LOW) |-> ($stable(lo_len) && $stable(div_act)));

  // R8: the falling strobe only ever marks a driven-low cycle
  p_fall_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> pull_low);

  // R10: with no request the high phase never leads into a new low phase
  p_stop_on_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HIGH && !req) |=> (state != PH_LOW));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             byte_req,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             scl_in,
  output logic             scl_pull_low,
  output logic             fall_stb,
  output logic             upd_stb,
  output logic             rise_stb,
  output logic             smp_stb
);
  logic              scl_hi;
  logic              tick;
  logic              run;
  logic [DIV_W-1:0]  div_reg, div_act;
  logic [TIME_W-1:0] tim_reg;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (scl_in),
    .line_sync (scl_hi)
  );

  scl_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .div_q     (div_reg),
    .tim_q     (tim_reg)
  );

  scl_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .div   (div_act),
    .tick  (tick)
  );

  scl_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (gen_en),
    .req      (byte_req),
    .scl_hi   (scl_hi),
    .tick     (tick),
    .div_reg  (div_reg),
    .tim_reg  (tim_reg),
    .run      (run),
    .div_act  (div_act),
    .pull_low (scl_pull_low),
    .fall_stb (fall_stb),
    .upd_stb  (upd_stb),
    .rise_stb (rise_stb),
    .smp_stb  (smp_stb)
  );
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b0;
  logic        byte_req = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        scl_pull_low, fall_stb, upd_stb, rise_stb, smp_stb;

  always #4 clk = ~clk;

  assign scl_in = !scl_pull_low && !stretch;

  scl_timing_gen #(.DIV_W(16), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .byte_req(byte_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .scl_in(scl_in),
    .scl_pull_low(scl_pull_low), .fall_stb(fall_stb), .upd_stb(upd_stb),
    .rise_stb(rise_stb), .smp_stb(smp_stb)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int low_cnt = 0;

  typedef struct {
    int    kind;
    int    stamp;
    string tag;
  } ev_t;
  ev_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push_ev(input int kind, input int stamp, input string tag);
    ev_t e;
    e.kind = kind;
    e.stamp = stamp;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Expected strobes of one clock period: 0 fall, 1 update, 2 rise, 3 sample
  task automatic push_period(input int t0, input int dl, input int l, input int dh, input int h,
                             input int th_min, input string tag, output int th, output int t_next);
    int w;
    w  = t0 + l * (dl + 1);
    th = w + SYNC + 1;
    if (th_min > th) th = th_min;
    push_ev(0, t0, tag);
    push_ev(1, t0 + (l / 2) * (dl + 1) - 1, tag);
    push_ev(2, th, tag);
    push_ev(3, th + (h / 2) * (dh + 1) - 1, tag);
    t_next = th + h * (dh + 1);
  endtask

  // Monitor: pops the scoreboard whenever the design emits a strobe
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] stb;
      stb = {smp_stb, rise_stb, upd_stb, fall_stb};
      if (scl_pull_low) low_cnt++;
      for (int k = 0; k < 4; k++) begin
        if (stb[k]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected strobe kind", k, -1);
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            chk(e.kind == k, e.tag, "strobe kind", k, e.kind);
            chk(e.stamp == cyc, e.tag, $sformatf("kind %0d strobe cycle", k), cyc, e.stamp);
          end
        end
      end
    end
  end

  task automatic wait_stamp(input int s);
    while (cyc < s) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] pack(input int h, input int l);
    return 16'(((h - 2) << 4) | (l - 2));
  endfunction

  task automatic end_checks(input int t_end, input int exp_low, input string tag);
    wait_stamp(t_end + 4);
    chk(scl_pull_low == 1'b0, "R10", "line released after stop", int'(scl_pull_low), 0);
    chk(exp_q.size() == 0, tag, "strobes still outstanding", exp_q.size(), 0);
    chk(low_cnt == exp_low, "R3", {tag, " driven-low cycles"}, low_cnt, exp_low);
  endtask

  task automatic burst(input int d, input int l, input int h, input int n, input string tag);
    int c, t, th, tn;
    @(negedge clk);
    low_cnt = 0;
    c = cyc;
    byte_req = 1'b1;
    t = c + 1;
    for (int i = 0; i < n; i++) begin
      push_period(t, d, l, d, h, 0, tag, th, tn);
      if (i == n - 1) begin
        wait_stamp(th);
        byte_req = 1'b0;
      end
      t = tn;
    end
    end_checks(t, n * l * (d + 1), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 200000);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c, t0, th, tn, th2, tn2, w, s;
    gen_en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(scl_pull_low == 1'b0, "R1", "line released after reset", int'(scl_pull_low), 0);
    chk({fall_stb, upd_stb, rise_stb, smp_stb} == 4'b0, "R1", "strobes after reset",
        int'({fall_stb, upd_stb, rise_stb, smp_stb}), 0);
    burst(0, 2, 2, 3, "R1");

    // R2 R3 R4 R7: packed word, fast divisor, unequal phases
    write_cfg(2'd0, 16'd3);
    write_cfg(2'd1, pack(9, 5));
    burst(3, 5, 9, 2, "R3");

    // R2: large divisor
    write_cfg(2'd0, 16'd1000);
    write_cfg(2'd1, pack(2, 2));
    burst(1000, 2, 2, 1, "R2");

    // R5: clamped requests, floor on high and ceiling on low
    write_cfg(2'd0, 16'd0);
    write_cfg(2'd2, {8'd0, 8'd15});
    burst(0, 9, 2, 2, "R5");
    // R5: ceiling on high and floor on low
    write_cfg(2'd0, 16'd2);
    write_cfg(2'd2, {8'd12, 8'd1});
    burst(2, 2, 9, 1, "R5");
    // R5: in-range pass through, then select 3 must change nothing
    write_cfg(2'd0, 16'd0);
    write_cfg(2'd2, {8'd7, 8'd4});
    write_cfg(2'd3, 16'hFFFF);
    burst(0, 4, 7, 2, "R5");

    // R9: writes during a low phase apply from the following high phase
    write_cfg(2'd0, 16'd2);
    write_cfg(2'd1, pack(4, 3));
    @(negedge clk);
    low_cnt = 0;
    c = cyc;
    byte_req = 1'b1;
    t0 = c + 1;
    push_period(t0, 2, 3, 1, 5, 0, "R9", th, tn);
    wait_stamp(t0 + 2);
    write_cfg(2'd1, pack(5, 6));
    write_cfg(2'd0, 16'd1);
    push_period(tn, 1, 6, 1, 5, 0, "R9", th2, tn2);
    wait_stamp(th2);
    byte_req = 1'b0;
    end_checks(tn2, 3 * 3 + 6 * 2, "R9");

    // R6: target holds SCL low after release
    write_cfg(2'd0, 16'd1);
    write_cfg(2'd1, pack(3, 2));
    @(negedge clk);
    low_cnt = 0;
    stretch = 1'b1;
    c = cyc;
    byte_req = 1'b1;
    t0 = c + 1;
    w = t0 + 2 * 2;
    s = w + 7;
    push_period(t0, 1, 2, 1, 3, s + SYNC + 1, "R6", th, tn);
    wait_stamp(s);
    chk(scl_pull_low == 1'b0, "R6", "line released while stretched", int'(scl_pull_low), 0);
    stretch = 1'b0;
    wait_stamp(th);
    byte_req = 1'b0;
    end_checks(tn, 4, "R6");

    // R11: enable dropped mid low phase
    write_cfg(2'd0, 16'd4);
    write_cfg(2'd1, pack(2, 9));
    @(negedge clk);
    c = cyc;
    byte_req = 1'b1;
    push_ev(0, c + 1, "R11");
    wait_stamp(c + 3);
    chk(scl_pull_low == 1'b1, "R11", "line driven before disable", int'(scl_pull_low), 1);
    gen_en = 1'b0;
    byte_req = 1'b0;
    wait_stamp(c + 4);
    chk(scl_pull_low == 1'b0, "R11", "line released after disable", int'(scl_pull_low), 0);
    repeat (6) @(negedge clk);
    gen_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(scl_pull_low == 1'b0, "R10", "stays idle without request", int'(scl_pull_low), 0);
    chk(exp_q.size() == 0, "R11", "strobes still outstanding", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule